// File: doc/BRIEF.md
# Rotating-Pointer Victim Selector

This block picks which entry of a fully associative store gets overwritten on the next refill. It keeps one pointer, and the pointer always names exactly one entry as the current replacement candidate. The pointer approximates recency. It moves off an entry only when that entry is used, so the entry it names has gone at least one trip around without being the one just used.

The surrounding cache reports each lookup hit by giving the index of the entry that matched. When that index is the one the pointer names, the pointer steps to the next entry, and after the last entry it goes back to entry 0. A hit on any other entry leaves the pointer where it is. When the cache writes a new line into the named entry, it raises a fill pulse. The fill counts as a use, so the pointer also steps by one. The block accepts at most one event per cycle.

The update is controlled by a two-state decision:
- STEP_HOLD: the pointer keeps its value.
- STEP_ADVANCE: the pointer moves to the next entry.

These transitions lead to STEP_ADVANCE:
- fill taken
- hit on the named entry

These transitions lead to STEP_HOLD:
- hit on another entry
- idle cycle

A change of the pointer appears on the victim output one clock after the event.

Top module: `victim_ptr_sel`

## Requirements
- R1: After reset is released, victim_idx is 0.
- R2: When hit_valid is high, fill_pulse is low and hit_idx equals victim_idx, victim_idx is one greater after the next clock edge.
- R3: When hit_valid is high, fill_pulse is low and hit_idx differs from victim_idx, victim_idx is unchanged after the next clock edge.
- R4: When victim_idx is ENTRIES-1 and an advance occurs, victim_idx becomes 0.
- R5: When fill_pulse is high, victim_idx is one greater (modulo ENTRIES) after the next clock edge.
- R6: When fill_pulse and hit_valid are high in the same cycle, the fill is the accepted event and the hit is ignored. victim_idx advances by exactly one, whatever hit_idx is.
- R7: In a cycle with neither hit_valid nor fill_pulse high, victim_idx keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_valid | input | 1 | A lookup hit occurred this cycle |
| hit_idx | input | IDXW | Index of the entry that hit |
| fill_pulse | input | 1 | The named entry is being refilled this cycle |
| victim_idx | output | IDXW | Entry to replace on the next fill |

## Verification
Assertions check every cycle that the pointer steps on a hit at the pointer, holds on a hit elsewhere, steps on a fill, and stays stable when idle. They also check that the step wraps from the last entry to 0 and that a fill beats a simultaneous hit.

Some behaviour can only be shown by the bench's scenarios: the reset value, long runs in which hits on the named entry are deliberately frequent so that the pointer completes full laps, and directed cases that pair a fill with a hit at the pointer or elsewhere.

// File: rtl/victim_ptr_pkg.sv
package victim_ptr_pkg;
    typedef enum logic [0:0] {
        STEP_HOLD    = 1'b0,
        STEP_ADVANCE = 1'b1
    } step_e;
endpackage

// File: rtl/victim_evt_decide.sv
module victim_evt_decide
    import victim_ptr_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDXW = $clog2(ENTRIES)
) (
    input  logic            hit_valid,
    input  logic [IDXW-1:0] hit_idx,
    input  logic            fill_pulse,
    input  logic [IDXW-1:0] cur_idx,
    output step_e           step
);
    logic hit_at_ptr;

    assign hit_at_ptr = hit_valid && (hit_idx == cur_idx);

    // A fill takes priority; a simultaneous hit is dropped (R6).
    always_comb begin
        if (fill_pulse) begin
            step = STEP_ADVANCE;
        end else if (hit_at_ptr) begin
            step = STEP_ADVANCE;
        end else begin
            step = STEP_HOLD;
        end
    end
endmodule

// File: rtl/victim_ptr_inc.sv
module victim_ptr_inc #(
    parameter int ENTRIES = 64,
    localparam int IDXW = $clog2(ENTRIES)
) (
    input  logic [IDXW-1:0] cur_idx,
    output logic [IDXW-1:0] nxt_idx
);
    // With a power-of-two entry count, the wrap comes from the natural
    // overflow of the adder; otherwise it needs an explicit compare.
    generate
        if ((1 << IDXW) == ENTRIES) begin : g_pow2
            assign nxt_idx = cur_idx + IDXW'(1);
        end else begin : g_cmp
            assign nxt_idx = (cur_idx == IDXW'(ENTRIES - 1)) ? '0 : cur_idx + IDXW'(1);
        end
    endgenerate
endmodule

// File: rtl/victim_ptr_sel.sv
module victim_ptr_sel
    import victim_ptr_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDXW = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_valid,
    input  logic [IDXW-1:0] hit_idx,
    input  logic            fill_pulse,
    output logic [IDXW-1:0] victim_idx
);
    step_e           step;
    logic [IDXW-1:0] ptr_q;
    logic [IDXW-1:0] ptr_inc;
    logic [IDXW-1:0] ptr_d;

    victim_evt_decide #(.ENTRIES(ENTRIES)) u_decide (
        .hit_valid (hit_valid),
        .hit_idx   (hit_idx),
        .fill_pulse(fill_pulse),
        .cur_idx   (ptr_q),
        .step      (step)
    );

    victim_ptr_inc #(.ENTRIES(ENTRIES)) u_inc (
        .cur_idx(ptr_q),
        .nxt_idx(ptr_inc)
    );

    always_comb begin
        unique case (step)
            STEP_ADVANCE: ptr_d = ptr_inc;
            STEP_HOLD:    ptr_d = ptr_q;
            default:      ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_comb begin
        victim_idx = ptr_q;
    end

    p_adv_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !fill_pulse && hit_idx == victim_idx)
        |=> (victim_idx == IDXW'($past(victim_idx) + IDXW'(1))));

    p_hold_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !fill_pulse && hit_idx != victim_idx)
        |=> $stable(victim_idx));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_idx == IDXW'(ENTRIES - 1) &&
         (fill_pulse || (hit_valid && hit_idx == victim_idx)))
        |=> (victim_idx == '0));

    p_fill_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_pulse && !hit_valid)
        |=> (victim_idx == IDXW'($past(victim_idx) + IDXW'(1))));

    p_fill_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_pulse && hit_valid)
        |=> (victim_idx == IDXW'($past(victim_idx) + IDXW'(1))));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_pulse && !hit_valid) |=> $stable(victim_idx));
endmodule

// File: tb/victim_ptr_sel_tb_top.sv
module victim_ptr_sel_tb_top;
    localparam int PERIOD  = 10;
    localparam int ENTRIES = 64;
    localparam int IDXW    = $clog2(ENTRIES);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hit_valid = 1'b0;
    logic [IDXW-1:0] hit_idx = '0;
    logic            fill_pulse = 1'b0;
    logic [IDXW-1:0] victim_idx;

    int total = 0;
    int bad = 0;
    int model = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    victim_ptr_sel #(.ENTRIES(ENTRIES)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_valid (hit_valid),
        .hit_idx   (hit_idx),
        .fill_pulse(fill_pulse),
        .victim_idx(victim_idx)
    );

    function automatic int next_ptr(int p, bit hv, int hi, bit fl);
        if (fl || (hv && hi == p)) return (p + 1) % ENTRIES;
        return p;
    endfunction

    function automatic string tag_of(int p, bit hv, int hi, bit fl);
        if (fl && hv) return "R6";
        if (fl) return (p == ENTRIES-1) ? "R4" : "R5";
        if (hv && hi == p) return (p == ENTRIES-1) ? "R4" : "R2";
        if (hv) return "R3";
        return "R7";
    endfunction

    task automatic check(string req);
        total++;
        if (int'(victim_idx) != model) begin
            bad++;
            $display("FAIL %s victim_idx actual=%0d expected=%0d", req, victim_idx, model);
        end
    endtask

    // Drive one cycle at the falling edge, then check at the next falling edge.
    task automatic step(bit hv, int hi, bit fl);
        string req;
        req = tag_of(model, hv, hi, fl);
        hit_valid  = hv;
        hit_idx    = IDXW'(hi);
        fill_pulse = fl;
        model = next_ptr(model, hv, hi, fl);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");
        // directed corner cases
        step(0, 0, 0);              // R7 idle
        step(1, 5, 0);              // R3 hit elsewhere
        step(1, 0, 0);              // R2 hit at pointer
        step(1, 1, 1);              // R6 fill with hit at pointer
        step(1, 40, 1);             // R6 fill with hit elsewhere
        step(0, 0, 1);              // R5 fill
        for (int i = 0; i < ENTRIES; i++) step(1, model, 0); // R4 full lap via hits
        for (int i = 0; i < ENTRIES; i++) step(0, 0, 1);     // R4 full lap via fills
        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit hv;
            bit fl;
            int hi;
            r  = int'($urandom_range(0, 9));
            hv = (r < 7);
            fl = ($urandom_range(0, 4) == 0);
            hi = ($urandom_range(0, 1) == 0) ? model : int'($urandom_range(0, ENTRIES-1));
            step(hv, hi, fl);
        end
        hit_valid = 1'b0;
        fill_pulse = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule